// File: doc/BRIEF.md
# Interval Timer and Interrupt Register Block

This block is a byte-wide memory-mapped peripheral with a 4-bit register address. It holds two 16-bit down-counters, an interrupt flag register, an interrupt enable register and one interrupt request line, plus a few plain storage bytes: two port data bytes, two port direction bytes, a shift byte, an auxiliary control byte, a peripheral control byte and a spare byte at offset 15. All counting advances only on cycles where the prescaled `tick_en` input is high. This lets a single fast clock drive a slow timebase.

The first timer reloads from a 16-bit latch. After the count passes through zero it shows 0xFFFF for one tick and then takes the latch value again. This gives a period of latch+2 ticks. In free-running mode every expiry raises its flag. The second timer is a plain 16-bit down-counter that is loaded through a low-byte holding register. Some reads and writes clear flags as a side effect, so software can acknowledge an interrupt just by touching the timer it serviced. A shift-complete event comes in on `shift_evt` and raises its own flag.

Bus accesses complete in one cycle. `bus_rdata` shows the addressed register combinationally. Every write, and every side effect of a read, takes effect at the rising edge of the access cycle.

Top module: `tick_timer_irq`

## Requirements
- R1: After reset, the timer-1 counter and latch read 0xFFFF, the timer-2 counter reads 0xFFFF, the enable register reads 0x80 and the flag register reads 0x00.
- R2: On each tick, timer 1 steps down by one until it reaches zero. The next tick sets it to 0xFFFF, and the tick after that loads the latch, so one period is latch+2 ticks. Offset 4 reads the counter low byte and offset 5 the high byte.
- R3: An expiry is a tick that finds timer 1 at zero. When auxiliary byte (offset 11) bits [7:6] equal 01, each expiry sets flag bit 6. With any other value of those bits, expiries leave the flags untouched.
- R4: Writing offset 4 or 6 sets the latch low byte. Writing offset 7 sets the latch high byte and clears flag bit 6 without touching the counter. Writing offset 5 sets the latch high byte, copies the whole latch into the counter and clears flag bit 6. Offsets 6/7 read back the latch bytes.
- R5: Reading offset 4 clears flag bit 6, reading offset 8 clears flag bit 5, and reading offset 10 clears flag bit 2.
- R6: Writing offset 8 stores a low holding byte. Writing offset 9 loads timer 2 with {written byte, holding byte}. Timer 2 steps down by one on each tick and wraps from 0 to 0xFFFF. A tick that finds it at zero sets flag bit 5. Offsets 8/9 read its low and high bytes.
- R7: Writing offset 13 clears every flag bit written as 1. Reading offset 13 returns the flags in bits [6:0], with bit 7 set when any flag is both set and enabled. `shift_evt` sets flag bit 2. When a set and a clear hit the same bit in one cycle, the set wins.
- R8: A write to offset 14 with bit 7 = 1 sets the enable bits given as ones in [6:0]. With bit 7 = 0 it clears them. Reading offset 14 always returns bit 7 = 1.
- R9: `irq` is high exactly when flag bit 2 or flag bit 6 is set together with its enable. Flag bit 5 never drives `irq`.
- R10: Neither counter changes on a cycle with `tick_en` low unless it is being loaded.
- R11: Offsets 0, 1, 2, 3, 10, 11, 12 and 15 read back the last byte written to them, and read 0 after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Prescaled count enable |
| bus_en | input | 1 | Register access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| shift_evt | input | 1 | Shift-complete event, sets flag bit 2 |
| irq | output | 1 | Interrupt request |

## Verification
Assertions check on every cycle the structural rules: the timer-1 wrap to 0xFFFF followed by the latch reload, the load on a high-byte write, timer-2 decrement and hold without a tick, set-beats-clear in the flag register, enable set/clear writes, and `irq` staying low unless a flag or enable actually changes. Only the bench scenarios can show whole-period lengths, flag outcomes of mode changes, read-side-effect clears seen through the bus, and the summary bit, because these span many cycles and mix register state with bus traffic.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [3:0] {
    OFS_PDB  = 4'd0,
    OFS_PDA  = 4'd1,
    OFS_DIRB = 4'd2,
    OFS_DIRA = 4'd3,
    OFS_T1CL = 4'd4,
    OFS_T1CH = 4'd5,
    OFS_T1LL = 4'd6,
    OFS_T1LH = 4'd7,
    OFS_T2L  = 4'd8,
    OFS_T2H  = 4'd9,
    OFS_SHF  = 4'd10,
    OFS_AUX  = 4'd11,
    OFS_PER  = 4'd12,
    OFS_FLG  = 4'd13,
    OFS_ENA  = 4'd14,
    OFS_SPR  = 4'd15
  } reg_ofs_e;

  // flag bit positions
  localparam int FLG_SHF = 2;
  localparam int FLG_T2  = 5;
  localparam int FLG_T1  = 6;

  // auxiliary control: timer-1 mode field and its free-running code
  localparam int        AUX_MODE_HI = 7;
  localparam int        AUX_MODE_LO = 6;
  localparam logic [1:0] MODE_FREE  = 2'b01;

  // offsets that are plain read/write storage
  function automatic logic is_plain(input int ofs);
    case (ofs)
      0, 1, 2, 3, 10, 11, 12, 15: is_plain = 1'b1;
      default:                    is_plain = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/tmr_t1_unit.sv
module tmr_t1_unit #(
  parameter int BYTE_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick,
  input  logic                  wr_lat_lo,
  input  logic                  wr_lat_hi,
  input  logic                  wr_cnt_hi,
  input  logic [BYTE_W-1:0]     wdata,
  output logic [2*BYTE_W-1:0]   cnt_o,
  output logic [2*BYTE_W-1:0]   latch_o,
  output logic                  expire_o
);
  localparam int CNT_W = 2*BYTE_W;

  logic [CNT_W-1:0] cnt_q, latch_q, load_val;
  logic             wrap_q;
  logic [CNT_W:0]   stepped;

  // one tick of the period: ...,1,0,all-ones,latch,...
  function automatic logic [CNT_W:0] t1_step(input logic [CNT_W-1:0] cnt,
                                             input logic wrap,
                                             input logic [CNT_W-1:0] latch);
    if (wrap)            t1_step = {1'b0, latch};
    else if (cnt == '0)  t1_step = {1'b1, {CNT_W{1'b1}}};
    else                 t1_step = {1'b0, cnt - 1'b1};
  endfunction

  assign stepped  = t1_step(cnt_q, wrap_q, latch_q);
  assign load_val = {wdata, latch_q[BYTE_W-1:0]};
  assign expire_o = tick && !wr_cnt_hi && !wrap_q && (cnt_q == '0);
  assign cnt_o    = cnt_q;
  assign latch_o  = latch_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '1;
      latch_q <= '1;
      wrap_q  <= 1'b0;
    end else if (wr_cnt_hi) begin
      latch_q <= load_val;
      cnt_q   <= load_val;
      wrap_q  <= 1'b0;
    end else begin
      if (tick) begin
        cnt_q  <= stepped[CNT_W-1:0];
        wrap_q <= stepped[CNT_W];
      end
      if (wr_lat_lo) latch_q[BYTE_W-1:0]     <= wdata;
      if (wr_lat_hi) latch_q[CNT_W-1:BYTE_W] <= wdata;
    end
  end

  p_reload_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_cnt_hi && wrap_q) |=> (cnt_q == $past(latch_q)));

  p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_cnt_hi && !wrap_q && cnt_q == '0) |=> (cnt_q == {CNT_W{1'b1}}));

  p_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt_hi |=> (cnt_q == latch_q && cnt_q[CNT_W-1:BYTE_W] == $past(wdata)));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_cnt_hi) |=> $stable(cnt_q));

endmodule

// File: rtl/tmr_t2_unit.sv
module tmr_t2_unit #(
  parameter int BYTE_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick,
  input  logic                  wr_lo,
  input  logic                  wr_hi,
  input  logic [BYTE_W-1:0]     wdata,
  output logic [2*BYTE_W-1:0]   cnt_o,
  output logic                  underflow_o
);
  localparam int CNT_W = 2*BYTE_W;

  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] lo_q;

  assign cnt_o       = cnt_q;
  assign underflow_o = tick && !wr_hi && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '1;
      lo_q  <= '0;
    end else begin
      if (wr_lo) lo_q <= wdata;
      if (wr_hi)     cnt_q <= {wdata, lo_q};
      else if (tick) cnt_q <= cnt_q - 1'b1;
    end
  end

  p_t2_dec_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_hi) |=> (cnt_q == $past(cnt_q) - 1'b1));

  p_t2_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi |=> (cnt_q == {$past(wdata), $past(lo_q)}));

  p_t2_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_hi) |=> $stable(cnt_q));

endmodule

// File: rtl/tmr_irq_regs.sv
module tmr_irq_regs #(
  parameter int               FLG_W    = 7,
  parameter logic [FLG_W-1:0] IRQ_MASK = 7'h44
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [FLG_W-1:0] set_vec,
  input  logic [FLG_W-1:0] clr_vec,
  input  logic             ena_wr,
  input  logic [FLG_W:0]   ena_wdata,
  output logic [FLG_W-1:0] flags_o,
  output logic [FLG_W-1:0] ena_o,
  output logic             summary_o,
  output logic             irq_o
);
  logic [FLG_W-1:0] flags_q, ena_q;

  // bit FLG_W selects set (1) or clear (0) for the ones in the lower bits
  function automatic logic [FLG_W-1:0] ena_next(input logic [FLG_W-1:0] cur,
                                                input logic [FLG_W:0] w);
    if (w[FLG_W]) ena_next = cur | w[FLG_W-1:0];
    else          ena_next = cur & ~w[FLG_W-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags_q <= '0;
      ena_q   <= '0;
    end else begin
      flags_q <= (flags_q & ~clr_vec) | set_vec;
      if (ena_wr) ena_q <= ena_next(ena_q, ena_wdata);
    end
  end

  assign flags_o   = flags_q;
  assign ena_o     = ena_q;
  assign summary_o = |(flags_q & ena_q);
  assign irq_o     = |(flags_q & ena_q & IRQ_MASK);

  p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((flags_q & $past(set_vec)) == $past(set_vec)));

  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_vec != '0) |=> ((flags_q & $past(clr_vec) & ~$past(set_vec)) == '0));

  p_no_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec == '0) |=> ((flags_q & ~$past(flags_q)) == '0));

  p_ena_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ena_wr && ena_wdata[FLG_W]) |=>
      ((ena_q & $past(ena_wdata[FLG_W-1:0])) == $past(ena_wdata[FLG_W-1:0])));

  p_ena_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ena_wr && !ena_wdata[FLG_W]) |=> ((ena_q & $past(ena_wdata[FLG_W-1:0])) == '0));

  p_irq_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_o && set_vec == '0 && !ena_wr) |=> !irq_o);

endmodule

// File: rtl/tick_timer_irq.sv
module tick_timer_irq #(
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  input  logic              shift_evt,
  output logic              irq
);
  import tmr_pkg::*;

  localparam int NREG  = 1 << ADDR_W;
  localparam int CNT_W = 2*BYTE_W;
  localparam int FLG_W = BYTE_W - 1;
  localparam logic [FLG_W-1:0] IRQ_MASK = FLG_W'((1 << FLG_SHF) | (1 << FLG_T1));

  logic [NREG-1:0]   wr_hit, rd_hit;
  logic [BYTE_W-1:0] plain_q [NREG];
  logic [CNT_W-1:0]  t1_cnt, t1_latch, t2_cnt;
  logic              t1_expire, t2_underflow, free_mode;
  logic [FLG_W-1:0]  set_vec, clr_vec, flags, ena;
  logic              flg_sum;

  // one-hot access strobes per offset
  for (genvar g = 0; g < NREG; g++) begin : g_dec
    assign wr_hit[g] = bus_en &&  bus_we && (bus_addr == ADDR_W'(g));
    assign rd_hit[g] = bus_en && !bus_we && (bus_addr == ADDR_W'(g));
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NREG; i++) begin
      if (!rst_n)                         plain_q[i] <= '0;
      else if (wr_hit[i] && is_plain(i)) plain_q[i] <= bus_wdata;
    end
  end

  assign free_mode = (plain_q[int'(OFS_AUX)][AUX_MODE_HI:AUX_MODE_LO] == MODE_FREE);

  tmr_t1_unit #(.BYTE_W(BYTE_W)) u_t1 (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick_en),
    .wr_lat_lo (wr_hit[int'(OFS_T1CL)] || wr_hit[int'(OFS_T1LL)]),
    .wr_lat_hi (wr_hit[int'(OFS_T1LH)]),
    .wr_cnt_hi (wr_hit[int'(OFS_T1CH)]),
    .wdata     (bus_wdata),
    .cnt_o     (t1_cnt),
    .latch_o   (t1_latch),
    .expire_o  (t1_expire)
  );

  tmr_t2_unit #(.BYTE_W(BYTE_W)) u_t2 (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick_en),
    .wr_lo       (wr_hit[int'(OFS_T2L)]),
    .wr_hi       (wr_hit[int'(OFS_T2H)]),
    .wdata       (bus_wdata),
    .cnt_o       (t2_cnt),
    .underflow_o (t2_underflow)
  );

  always_comb begin
    set_vec          = '0;
    set_vec[FLG_T1]  = t1_expire && free_mode;
    set_vec[FLG_T2]  = t2_underflow;
    set_vec[FLG_SHF] = shift_evt;
    clr_vec          = wr_hit[int'(OFS_FLG)] ? bus_wdata[FLG_W-1:0] : '0;
    if (rd_hit[int'(OFS_T1CL)] || wr_hit[int'(OFS_T1CH)] || wr_hit[int'(OFS_T1LH)])
      clr_vec[FLG_T1] = 1'b1;
    if (rd_hit[int'(OFS_T2L)]) clr_vec[FLG_T2]  = 1'b1;
    if (rd_hit[int'(OFS_SHF)]) clr_vec[FLG_SHF] = 1'b1;
  end

  tmr_irq_regs #(.FLG_W(FLG_W), .IRQ_MASK(IRQ_MASK)) u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_vec   (set_vec),
    .clr_vec   (clr_vec),
    .ena_wr    (wr_hit[int'(OFS_ENA)]),
    .ena_wdata (bus_wdata),
    .flags_o   (flags),
    .ena_o     (ena),
    .summary_o (flg_sum),
    .irq_o     (irq)
  );

  always_comb begin
    bus_rdata = plain_q[bus_addr];
    case (bus_addr)
      ADDR_W'(OFS_T1CL): bus_rdata = t1_cnt[BYTE_W-1:0];
      ADDR_W'(OFS_T1CH): bus_rdata = t1_cnt[CNT_W-1:BYTE_W];
      ADDR_W'(OFS_T1LL): bus_rdata = t1_latch[BYTE_W-1:0];
      ADDR_W'(OFS_T1LH): bus_rdata = t1_latch[CNT_W-1:BYTE_W];
      ADDR_W'(OFS_T2L):  bus_rdata = t2_cnt[BYTE_W-1:0];
      ADDR_W'(OFS_T2H):  bus_rdata = t2_cnt[CNT_W-1:BYTE_W];
      ADDR_W'(OFS_FLG):  bus_rdata = {flg_sum, flags};
      ADDR_W'(OFS_ENA):  bus_rdata = {1'b1, ena};
      default: ;
    endcase
  end

  p_free_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (t1_expire && free_mode) |=> flags[FLG_T1]);

  p_mode_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!free_mode && !flags[FLG_T1]) |=> !flags[FLG_T1]);

  p_rd_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit[int'(OFS_T2L)] && !t2_underflow) |=> !flags[FLG_T2]);

endmodule

// File: tb/tick_timer_irq_tb_top.sv
module tick_timer_irq_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic       bus_en = 1'b0;
  logic       bus_we = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       shift_evt = 1'b0;
  logic       irq;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  tick_timer_irq dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_en(bus_en),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .shift_evt(shift_evt), .irq(irq)
  );

  // reference state: timer-1 position (-1 stands for the all-ones step)
  int         m_t1_pos = 65535;
  logic [15:0] m_t1_lat = 16'hFFFF;
  logic [15:0] m_t2 = 16'hFFFF;
  logic [7:0]  m_t2_lo = '0;
  logic [6:0]  m_ifr = '0;
  logic [6:0]  m_ier = '0;
  logic [7:0]  m_store [16];

  function automatic logic [15:0] t1_val();
    return (m_t1_pos < 0) ? 16'hFFFF : 16'(m_t1_pos);
  endfunction

  function automatic logic [7:0] m_read(input logic [3:0] a);
    logic [15:0] v;
    v = t1_val();
    case (a)
      4'd4:  return v[7:0];
      4'd5:  return v[15:8];
      4'd6:  return m_t1_lat[7:0];
      4'd7:  return m_t1_lat[15:8];
      4'd8:  return m_t2[7:0];
      4'd9:  return m_t2[15:8];
      4'd13: return {|(m_ifr & m_ier), m_ifr};
      4'd14: return {1'b1, m_ier};
      default: return m_store[a];
    endcase
  endfunction

  function automatic string tag_of(input logic [3:0] a);
    case (a)
      4'd4, 4'd5: return "R2";
      4'd6, 4'd7: return "R4";
      4'd8, 4'd9: return "R6";
      4'd13:      return "R7";
      4'd14:      return "R8";
      default:    return "R11";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  // one bus cycle: drive at falling edge, check, advance the model for the next rising edge
  task automatic cyc(input bit en, input bit we, input logic [3:0] a, input logic [7:0] d,
                     input bit tk, input bit sh, input string tag);
    bit w, r, t1_ld, t2_ld;
    logic [6:0] setv, clrv;
    @(negedge clk);
    bus_en = en; bus_we = we; bus_addr = a; bus_wdata = d; tick_en = tk; shift_evt = sh;
    #1;
    chk("R9", {7'd0, irq}, {7'd0, |(m_ifr & m_ier & 7'h44)});
    if (en && !we) chk((tag == "") ? tag_of(a) : tag, bus_rdata, m_read(a));
    w = en && we; r = en && !we;
    t1_ld = w && a == 4'd5;
    t2_ld = w && a == 4'd9;
    setv = '0; clrv = '0;
    if (tk && m_t1_pos == 0 && !t1_ld && m_store[11][7:6] == 2'b01) setv[6] = 1'b1;
    if (tk && m_t2 == 16'd0 && !t2_ld) setv[5] = 1'b1;
    if (sh) setv[2] = 1'b1;
    if (w && a == 4'd13) clrv = d[6:0];
    if ((r && a == 4'd4) || (w && (a == 4'd5 || a == 4'd7))) clrv[6] = 1'b1;
    if (r && a == 4'd8)  clrv[5] = 1'b1;
    if (r && a == 4'd10) clrv[2] = 1'b1;
    m_ifr = (m_ifr & ~clrv) | setv;
    if (t1_ld) begin
      m_t1_lat[15:8] = d;
      m_t1_pos = int'(m_t1_lat);
    end else begin
      if (tk) m_t1_pos = (m_t1_pos < 0) ? int'(m_t1_lat) : m_t1_pos - 1;
      if (w && (a == 4'd4 || a == 4'd6)) m_t1_lat[7:0] = d;
      if (w && a == 4'd7) m_t1_lat[15:8] = d;
    end
    if (w && a == 4'd8) m_t2_lo = d;
    if (t2_ld) m_t2 = {d, m_t2_lo};
    else if (tk) m_t2 = m_t2 - 16'd1;
    if (w && a == 4'd14) m_ier = d[7] ? (m_ier | d[6:0]) : (m_ier & ~d[6:0]);
    if (w && (a <= 4'd3 || a == 4'd10 || a == 4'd11 || a == 4'd12 || a == 4'd15)) m_store[a] = d;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d, input bit tk, input string tag);
    cyc(1'b1, 1'b1, a, d, tk, 1'b0, tag);
  endtask

  task automatic rd(input logic [3:0] a, input bit tk, input string tag);
    cyc(1'b1, 1'b0, a, 8'd0, tk, 1'b0, tag);
  endtask

  task automatic idle(input int n, input bit tk);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 4'd0, 8'd0, tk, 1'b0, "");
  endtask

  initial begin : watchdog
    #2000000;
    fails++;
    $display("FAIL watchdog: actual running expected done");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin : main
    int seed;
    logic [3:0] a;
    logic [7:0] d;
    for (int i = 0; i < 16; i++) m_store[i] = '0;
    seed = $urandom(32'd1234);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset values
    rd(4'd4, 0, "R1"); rd(4'd5, 0, "R1"); rd(4'd6, 0, "R1"); rd(4'd7, 0, "R1");
    rd(4'd8, 0, "R1"); rd(4'd9, 0, "R1"); rd(4'd13, 0, "R1"); rd(4'd14, 0, "R1");
    rd(4'd11, 0, "R1");

    // R3/R2: free-running, latch 2 => period 4, flag on each expiry
    wr(4'd11, 8'h40, 0, "R3");
    wr(4'd14, 8'hC4, 0, "R8");
    wr(4'd4, 8'd2, 0, "R4");
    wr(4'd5, 8'd0, 0, "R4");
    for (int i = 0; i < 9; i++) rd(4'd5, 1, "R2");
    rd(4'd13, 0, "R3");
    rd(4'd4, 0, "R5");
    rd(4'd13, 0, "R5");
    // R3: other mode, no flag
    wr(4'd11, 8'h80, 0, "R3");
    for (int i = 0; i < 8; i++) rd(4'd13, 1, "R3");
    wr(4'd11, 8'h00, 0, "R3");
    for (int i = 0; i < 8; i++) rd(4'd4, 1, "R2");
    rd(4'd13, 0, "R3");

    // R4: latch-high write clears flag without reload
    wr(4'd11, 8'h40, 0, "R3");
    idle(6, 1);
    rd(4'd13, 0, "R3");
    wr(4'd6, 8'h33, 0, "R4");
    wr(4'd7, 8'h01, 0, "R4");
    rd(4'd13, 0, "R4"); rd(4'd4, 0, "R4"); rd(4'd6, 0, "R4"); rd(4'd7, 0, "R4");

    // R10: no tick, no change
    wr(4'd8, 8'h34, 0, "R6");
    wr(4'd9, 8'h12, 0, "R6");
    for (int i = 0; i < 4; i++) rd(4'd8, 0, "R10");
    rd(4'd4, 0, "R10");
    rd(4'd8, 1, "R6"); rd(4'd9, 0, "R6");

    // R6: timer-2 underflow sets bit 5, read clears (R5), bit 5 alone never drives irq (R9)
    wr(4'd14, 8'h7F, 0, "R8");
    wr(4'd14, 8'hA0, 0, "R8");
    wr(4'd8, 8'd1, 0, "R6");
    wr(4'd9, 8'd0, 0, "R6");
    idle(3, 1);
    rd(4'd13, 0, "R6");
    rd(4'd9, 0, "R6");
    rd(4'd8, 0, "R5");
    rd(4'd13, 0, "R5");

    // R7: shift event sets bit 2, set wins over a same-cycle clear
    wr(4'd14, 8'h84, 0, "R8");
    cyc(1'b1, 1'b1, 4'd13, 8'h04, 1'b0, 1'b1, "R7");
    rd(4'd13, 0, "R7");
    wr(4'd13, 8'h04, 0, "R7");
    rd(4'd13, 0, "R7");
    cyc(1'b0, 1'b0, 4'd0, 8'd0, 1'b0, 1'b1, "R7");
    rd(4'd10, 0, "R5");
    rd(4'd13, 0, "R5");
    wr(4'd14, 8'h04, 0, "R8");
    rd(4'd14, 0, "R8");

    // R11: plain storage
    wr(4'd0, 8'hA5, 0, "R11"); wr(4'd1, 8'h5A, 0, "R11"); wr(4'd2, 8'h0F, 0, "R11");
    wr(4'd3, 8'hF0, 0, "R11"); wr(4'd10, 8'h3C, 0, "R11"); wr(4'd12, 8'hC3, 0, "R11");
    wr(4'd15, 8'h99, 0, "R11");
    for (int i = 0; i < 16; i++) if (i <= 3 || i == 10 || i == 12 || i == 15) rd(4'(i), 0, "R11");

    // constrained random mix
    for (int n = 0; n < 4000; n++) begin
      a = 4'($urandom_range(0, 15));
      d = 8'($urandom);
      case (a)
        4'd4, 4'd6:  d = 8'($urandom_range(0, 20));
        4'd5, 4'd7, 4'd9: if ($urandom_range(0, 7) != 0) d = 8'd0;
        4'd8:        d = 8'($urandom_range(0, 30));
        4'd11:       d = {2'($urandom_range(0, 3)), 6'($urandom)};
        default: ;
      endcase
      cyc($urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1, a, d,
          $urandom_range(0, 2) == 0, $urandom_range(0, 22) == 0, "");
    end

    @(negedge clk);
    bus_en = 1'b0; tick_en = 1'b0; shift_evt = 1'b0;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule